// File: doc/BRIEF.md
# Paged Address Translation Buffer

This block is a small fully associative translation buffer that sits in front of the memory path. Each lookup carries a virtual address and a read/write flag. The upper bits form a virtual page number, which is compared in parallel against every stored entry. On a hit, the matching frame number replaces the page number, and the in-page offset passes through unchanged. The response is registered and appears one cycle after the request. It reports exactly one of three outcomes: a translated address, a miss, or a protection fault.

A miss or fault leaves all stored state untouched. The access can therefore be retried once a handler has installed the missing entry through the refill port. Each entry holds a resident bit, a used bit, a modified bit, two permission bits and the frame number. A successful access marks the entry used, and a successful write also marks it modified. A refill goes into the lowest-numbered empty slot. When no slot is empty, the refill replaces entries in rotating order. The displaced entry's page, frame, used and modified flags are reported for one cycle so the handler can write them back to the page table. A single input drops every entry at once.

Top module: `xlat_buffer`

## Requirements
- R1: After synchronous reset, no entry is resident, the response and eviction outputs are low, and any lookup misses.
- R2: A lookup accepted at a clock edge answers at that edge's register output. On a hit, rsp_paddr = {frame number, req_vaddr[11:0]}, with the page number taken from req_vaddr[31:12].
- R3: While rsp_valid is high, exactly one of rsp_hit, rsp_miss and rsp_fault is high. While rsp_valid is low, all three are low.
- R4: A miss changes no entry. After a refill installs the page, reissuing the same access hits.
- R5: A permitted access sets the entry's used flag, and a permitted write also sets its modified flag. A refill installs the entry with both flags clear.
- R6: The permission bits are fill_rd_ok (read allowed) and fill_wr_ok (write allowed). An access that its page does not allow gives a one-cycle rsp_fault with rsp_paddr zero, and it sets neither flag. A miss also returns rsp_paddr zero.
- R7: A refill writes the lowest-numbered non-resident slot and reports no eviction.
- R8: When all slots are resident, successive refills replace slots 0,1,2,... in rotation. Each such refill drives evict_valid for one cycle, one edge later, carrying the old page, frame, used flag and modified flag.
- R9: flush_all clears every resident bit at one edge. It takes priority over a refill in the same cycle, which is then dropped. Lookups issued afterwards miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_write | input | 1 | Request is a write |
| req_vaddr | input | 32 | Virtual address |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No resident entry for the page |
| rsp_fault | output | 1 | Access not permitted |
| rsp_paddr | output | 32 | Physical address on hit, zero otherwise |
| fill_valid | input | 1 | Install an entry |
| fill_vpn | input | 20 | Page number to install |
| fill_pfn | input | 20 | Frame number to install |
| fill_rd_ok | input | 1 | Reads allowed on the page |
| fill_wr_ok | input | 1 | Writes allowed on the page |
| flush_all | input | 1 | Drop every entry |
| evict_valid | output | 1 | A resident entry was replaced |
| evict_vpn | output | 20 | Page of the replaced entry |
| evict_pfn | output | 20 | Frame of the replaced entry |
| evict_ref | output | 1 | Used flag of the replaced entry |
| evict_dirty | output | 1 | Modified flag of the replaced entry |

## Verification
The bound checker watches, on every cycle, the outcome encoding of the response. It also checks the one-cycle request-to-response relation, the zero address on a miss or fault, the misses that follow a flush, and that an eviction report always follows a refill. Several behaviours only appear in the bench's scenarios, compared cycle by cycle against a behavioural model: whether the used and modified flags were updated, the slot a refill chose, the rotation order, and the absence of side effects from misses and faults. These are visible at the ports only later, through hits after a refill or through the contents of eviction reports.

// File: rtl/xlat_pkg.sv
// Shared definitions for the translation buffer.
// Assumes: permission check depends only on access direction and two bits.
package xlat_pkg;

    // Outcome of a single lookup
    typedef enum logic [1:0] {
        LK_NONE  = 2'd0,
        LK_HIT   = 2'd1,
        LK_MISS  = 2'd2,
        LK_FAULT = 2'd3
    } lk_kind_e;

    // Returns 1 when the access direction is permitted by the page bits
    function automatic logic access_ok(input logic is_write,
                                       input logic rd_ok,
                                       input logic wr_ok);
        return is_write ? wr_ok : rd_ok;
    endfunction

endpackage

// File: rtl/xlat_cam.sv
// Parallel page-number match over all slots.
// Assumes: at most one resident slot holds a given page; the lowest index wins otherwise.
module xlat_cam #(
    parameter int N     = 8,
    parameter int VPN_W = 20,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]            resident,
    input  logic [N-1:0][VPN_W-1:0] tag_tab,
    input  logic [VPN_W-1:0]        key,
    output logic [N-1:0]            hit_vec,
    output logic                    any_hit,
    output logic [IDX_W-1:0]        hit_idx
);

    // One comparator per slot
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = resident[g] && (tag_tab[g] == key);
    end

    assign any_hit = |hit_vec;

    // Encode the lowest matching slot
    always_comb begin
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/xlat_victim.sv
// Chooses the slot a refill writes: lowest empty one, else a rotating pointer.
// Assumes: advance is asserted only when a refill lands while all slots are resident.
module xlat_victim #(
    parameter int N = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     resident,
    input  logic             advance,
    output logic [IDX_W-1:0] victim_idx,
    output logic             all_full
);

    logic [IDX_W-1:0] first_free;
    logic [IDX_W-1:0] rr_q;

    // Lowest non-resident slot
    always_comb begin
        first_free = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!resident[i]) first_free = IDX_W'(i);
        end
    end

    assign all_full   = &resident;
    assign victim_idx = all_full ? rr_q : first_free;

    // Rotating replacement pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (advance) begin
            rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
        end
    end

endmodule

// File: rtl/xlat_buffer.sv
// Fully associative address translation buffer with per-page used, modified
// and permission state, one-cycle registered response and refill port.
// Assumes: the handler never installs a page that is already resident.
module xlat_buffer #(
    parameter int N     = 8,
    parameter int VPN_W = 20,
    parameter int OFS_W = 12,
    parameter int PFN_W = 20,
    localparam int VA_W  = VPN_W + OFS_W,
    localparam int PA_W  = PFN_W + OFS_W,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_fault,
    output logic [PA_W-1:0]  rsp_paddr,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_rd_ok,
    input  logic             fill_wr_ok,
    input  logic             flush_all,
    output logic             evict_valid,
    output logic [VPN_W-1:0] evict_vpn,
    output logic [PFN_W-1:0] evict_pfn,
    output logic             evict_ref,
    output logic             evict_dirty
);
    import xlat_pkg::*;

    logic [N-1:0]            res_q, ref_q, mod_q, rd_q, wr_q;
    logic [N-1:0][VPN_W-1:0] vpn_q;
    logic [N-1:0][PFN_W-1:0] pfn_q;

    logic [VPN_W-1:0] lk_vpn;
    logic [OFS_W-1:0] lk_ofs;
    logic [N-1:0]     hit_vec;
    logic             any_hit;
    logic [IDX_W-1:0] hit_idx;
    logic [IDX_W-1:0] victim_idx;
    logic             all_full;
    logic             do_fill;
    logic             lk_allowed;
    lk_kind_e         lk_kind;

    assign lk_vpn  = req_vaddr[VA_W-1:OFS_W];
    assign lk_ofs  = req_vaddr[OFS_W-1:0];
    assign do_fill = fill_valid && !flush_all;

    xlat_cam #(.N(N), .VPN_W(VPN_W)) u_cam (
        .resident (res_q),
        .tag_tab  (vpn_q),
        .key      (lk_vpn),
        .hit_vec  (hit_vec),
        .any_hit  (any_hit),
        .hit_idx  (hit_idx)
    );

    xlat_victim #(.N(N)) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .resident   (res_q),
        .advance    (do_fill && all_full),
        .victim_idx (victim_idx),
        .all_full   (all_full)
    );

    // Classify the current lookup
    always_comb begin
        lk_allowed = access_ok(req_write, rd_q[hit_idx], wr_q[hit_idx]);
        if (!req_valid)      lk_kind = LK_NONE;
        else if (!any_hit)   lk_kind = LK_MISS;
        else if (lk_allowed) lk_kind = LK_HIT;
        else                 lk_kind = LK_FAULT;
    end

    // Register the lookup response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= (lk_kind != LK_NONE);
            rsp_hit   <= (lk_kind == LK_HIT);
            rsp_miss  <= (lk_kind == LK_MISS);
            rsp_fault <= (lk_kind == LK_FAULT);
            rsp_paddr <= (lk_kind == LK_HIT) ? {pfn_q[hit_idx], lk_ofs} : '0;
        end
    end

    // Per-slot flag state: lookup updates, then refill, then flush
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            ref_q <= '0;
            mod_q <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (lk_kind == LK_HIT && hit_vec[i]) begin
                    ref_q[i] <= 1'b1;
                    if (req_write) mod_q[i] <= 1'b1;
                end
                if (do_fill && victim_idx == IDX_W'(i)) begin
                    res_q[i] <= 1'b1;
                    ref_q[i] <= 1'b0;
                    mod_q[i] <= 1'b0;
                end
                if (flush_all) res_q[i] <= 1'b0;
            end
        end
    end

    // Per-slot payload written by refill
    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (do_fill && victim_idx == IDX_W'(i)) begin
                vpn_q[i] <= fill_vpn;
                pfn_q[i] <= fill_pfn;
                rd_q[i]  <= fill_rd_ok;
                wr_q[i]  <= fill_wr_ok;
            end
        end
    end

    // Report the entry displaced by a refill into a full buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evict_valid <= 1'b0;
            evict_vpn   <= '0;
            evict_pfn   <= '0;
            evict_ref   <= 1'b0;
            evict_dirty <= 1'b0;
        end else begin
            evict_valid <= do_fill && all_full;
            evict_vpn   <= vpn_q[victim_idx];
            evict_pfn   <= pfn_q[victim_idx];
            evict_ref   <= ref_q[victim_idx];
            evict_dirty <= mod_q[victim_idx];
        end
    end

endmodule

// File: rtl/xlat_buffer_chk.sv
// Cycle-level properties of the translation buffer, attached by bind.
// Assumes: sampled on the buffer's clock with its synchronous reset.
module xlat_buffer_chk #(
    parameter int VA_W = 32,
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [VA_W-1:0] req_vaddr,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic            rsp_miss,
    input logic            rsp_fault,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            fill_valid,
    input logic            flush_all,
    input logic            evict_valid
);

    // R3
    rsp_one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot({rsp_hit, rsp_miss, rsp_fault}));

    // R3
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));

    // R2
    rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    // R6
    no_addr_leak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault || rsp_miss) |-> (rsp_paddr == '0));

    // R9
    flush_misses_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flush_all, 2) && rsp_valid) |-> rsp_miss);

    // R8
    evict_from_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> ($past(fill_valid) && !$past(flush_all)));

endmodule

bind xlat_buffer xlat_buffer_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_vaddr   (req_vaddr),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_miss    (rsp_miss),
    .rsp_fault   (rsp_fault),
    .rsp_paddr   (rsp_paddr),
    .fill_valid  (fill_valid),
    .flush_all   (flush_all),
    .evict_valid (evict_valid)
);

// File: tb/test_xlat_buffer.sv
// Bench: behavioural model stepped on every clock, outputs compared each cycle.
module test_xlat_buffer;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [31:0] req_vaddr;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
    logic [31:0] rsp_paddr;
    logic        fill_valid, fill_rd_ok, fill_wr_ok, flush_all;
    logic [19:0] fill_vpn, fill_pfn;
    logic        evict_valid, evict_ref, evict_dirty;
    logic [19:0] evict_vpn, evict_pfn;

    int checks = 0;
    int errors = 0;
    string phase = "R1 reset";

    // model state
    bit m_res[8], m_ref[8], m_mod[8], m_rd[8], m_wr[8];
    int m_vpn[8], m_pfn[8];
    int m_rr;
    bit e_rv, e_h, e_m, e_f, e_ev, e_eref, e_emod;
    int e_pa, e_evpn, e_epfn;

    always #5 clk = ~clk;

    xlat_buffer i_xlat_buffer (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_rd_ok(fill_rd_ok), .fill_wr_ok(fill_wr_ok), .flush_all(flush_all),
        .evict_valid(evict_valid), .evict_vpn(evict_vpn), .evict_pfn(evict_pfn),
        .evict_ref(evict_ref), .evict_dirty(evict_dirty)
    );

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin
            m_res[i] = 0; m_ref[i] = 0; m_mod[i] = 0;
        end
        m_rr = 0;
        {e_rv, e_h, e_m, e_f, e_ev, e_eref, e_emod} = '0;
        e_pa = 0; e_evpn = 0; e_epfn = 0;
    endtask

    // Advance the model by one edge using the inputs currently applied
    task automatic model_step();
        int hi, vic;
        bit full;
        hi = -1;
        {e_rv, e_h, e_m, e_f} = '0;
        e_pa = 0;
        if (req_valid) begin
            e_rv = 1;
            for (int i = 7; i >= 0; i--)
                if (m_res[i] && m_vpn[i] == int'(req_vaddr[31:12])) hi = i;
            if (hi < 0) e_m = 1;
            else if (req_write ? m_wr[hi] : m_rd[hi]) begin
                e_h = 1;
                e_pa = (m_pfn[hi] << 12) | int'(req_vaddr[11:0]);
            end else begin
                e_f = 1;
            end
        end
        full = 1;
        vic = -1;
        for (int i = 7; i >= 0; i--) if (!m_res[i]) begin full = 0; vic = i; end
        if (full) vic = m_rr;
        e_ev = fill_valid && !flush_all && full;
        if (e_ev) begin
            e_evpn = m_vpn[vic]; e_epfn = m_pfn[vic];
            e_eref = m_ref[vic]; e_emod = m_mod[vic];
        end
        if (e_h) begin
            m_ref[hi] = 1;
            if (req_write) m_mod[hi] = 1;
        end
        if (fill_valid && !flush_all) begin
            m_res[vic] = 1; m_ref[vic] = 0; m_mod[vic] = 0;
            m_vpn[vic] = int'(fill_vpn); m_pfn[vic] = int'(fill_pfn);
            m_rd[vic] = fill_rd_ok; m_wr[vic] = fill_wr_ok;
            if (full) m_rr = (m_rr + 1) % 8;
        end
        if (flush_all) for (int i = 0; i < 8; i++) m_res[i] = 0;
    endtask

    task automatic compare();
        checks++;
        if (rsp_valid !== e_rv || rsp_hit !== e_h || rsp_miss !== e_m ||
            rsp_fault !== e_f || rsp_paddr !== e_pa[31:0]) begin
            errors++;
            $display("FAIL %s response: got v%0b h%0b m%0b f%0b pa %h, expected v%0b h%0b m%0b f%0b pa %h",
                     phase, rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr,
                     e_rv, e_h, e_m, e_f, e_pa[31:0]);
        end
        checks++;
        if (evict_valid !== e_ev ||
            (e_ev && (evict_vpn !== e_evpn[19:0] || evict_pfn !== e_epfn[19:0] ||
                      evict_ref !== e_eref || evict_dirty !== e_emod))) begin
            errors++;
            $display("FAIL %s eviction (R8 R5): got v%0b vpn %h pfn %h u%0b m%0b, expected v%0b vpn %h pfn %h u%0b m%0b",
                     phase, evict_valid, evict_vpn, evict_pfn, evict_ref, evict_dirty,
                     e_ev, e_evpn[19:0], e_epfn[19:0], e_eref, e_emod);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        #1;
        compare();
        req_valid = 0; fill_valid = 0; flush_all = 0;
    endtask

    task automatic lookup(input int vpn, input int ofs, input bit wr);
        req_valid = 1; req_write = wr;
        req_vaddr = {vpn[19:0], ofs[11:0]};
        cyc();
    endtask

    task automatic refill(input int vpn, input int pfn, input bit rd, input bit wr);
        fill_valid = 1; fill_vpn = vpn[19:0]; fill_pfn = pfn[19:0];
        fill_rd_ok = rd; fill_wr_ok = wr;
        cyc();
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; req_valid = 0; req_write = 0; req_vaddr = '0;
        fill_valid = 0; fill_vpn = '0; fill_pfn = '0;
        fill_rd_ok = 0; fill_wr_ok = 0; flush_all = 0;
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        compare();                       // R1 outputs low in reset
        rst_n = 1;
        lookup(5, 0, 0);                 // R1 empty buffer misses

        phase = "R2 R4 miss then refill";
        lookup('h12345, 'h678, 0);
        lookup('h12345, 'h678, 1);
        refill('h12345, 'hABCDE, 1, 1);
        lookup('h12345, 'h678, 0);
        lookup('h12345, 'hFFF, 1);

        phase = "R6 protection";
        refill('h00002, 'h00077, 1, 0);
        lookup('h00002, 'h010, 1);       // fault, no flag change
        lookup('h00002, 'h010, 0);       // hit
        refill('h00003, 'h00088, 0, 0);
        lookup('h00003, 'h001, 0);       // fault
        refill('h00004, 'h00099, 0, 1);
        lookup('h00004, 'h002, 0);       // fault
        lookup('h00004, 'h002, 1);       // hit, modified

        phase = "R7 lowest free slot";
        for (int k = 0; k < 4; k++) refill('h100 + k, 'h200 + k, 1, 1);
        lookup('h101, 0, 1);
        lookup('h102, 0, 0);

        phase = "R8 R5 rotation and write-back";
        for (int k = 0; k < 10; k++) refill('h300 + k, 'h400 + k, 1, 1);
        lookup('h305, 'h3, 1);
        lookup('h306, 'h3, 0);
        for (int k = 0; k < 8; k++) refill('h500 + k, 'h600 + k, 1, 1);

        phase = "R9 flush";
        flush_all = 1; fill_valid = 1; fill_vpn = 'h777; fill_pfn = 'h1;
        cyc();
        lookup('h500, 0, 0);
        lookup('h777, 0, 0);
        refill('h900, 'h901, 1, 1);      // R7 slot 0 after flush, no eviction
        lookup('h900, 'h5, 0);

        phase = "R3 mixed traffic";
        for (int n = 0; n < 600; n++) begin
            int v;
            bit used;
            req_valid = ($urandom % 3) != 0;
            req_write = $urandom % 2;
            req_vaddr = {20'($urandom % 12), 12'($urandom)};
            if (($urandom % 4) == 0) begin
                v = $urandom % 12;
                used = 0;
                for (int i = 0; i < 8; i++) if (m_res[i] && m_vpn[i] == v) used = 1;
                if (!used) begin
                    fill_valid = 1; fill_vpn = v[19:0]; fill_pfn = 20'($urandom);
                    fill_rd_ok = $urandom % 2; fill_wr_ok = $urandom % 2;
                end
            end
            flush_all = ($urandom % 50) == 0;
            cyc();
        end
        cyc();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule